// File: doc/BRIEF.md
# HD Timing Reference Decoder

This block sits at the pixel clock on a 10-bit multiplexed video stream for a 1125-line, two-field interlaced HD raster. It watches the stream for the three-word preamble that announces a timing reference (all ones, then two all-zero words). It then decodes the status word that follows into field, vertical-blank and horizontal-blank flags and checks the protection bits carried with them. From these codes it drives field, vertical-blank, horizontal-blank and data-valid outputs, so that no separate sync pins are needed.

The block keeps a line counter that advances on every end-of-active-video code. The counter is forced to the first line of the second field when the field flag rises and to line 1 when it falls. After each line start the decoded flags are compared with the expected two-field line map. A horizontal sample counter restarts on every start-of-active-video code. Both counters can be cleared by the chip reset, or by a control bit that is taken high and then low.

Top module: `hdTimingDecoder`

## Requirements
- R1: While `rstN` is low and after it is released, `lineNum` = 0, `sampleNum` = 0, `fieldOut` = 0, `vBlank` = 1, `hBlank` = 1, `protErr` = 0, `mapErr` = 0, and `dataValid` is at its inactive level.
- R2: A word is taken as a status word only when the three words before it were 0x3FF, 0x000 and 0x000, in that order. With any other preceding words, a word shaped like a status word changes no output.
- R3: A good status word with H (bit 6) = 1 marks end of active video. From the next cycle `hBlank` = 1, `dataValid` is inactive, `fieldOut` = F (bit 8) and `vBlank` = V (bit 7). `lineNum` advances by one, and 1125 is followed by 1.
- R4: A good status word with H = 0 marks start of active video. From the next cycle `hBlank` = 0 and `sampleNum` = 0, and `sampleNum` then counts up by one per sample. `dataValid` is active from that cycle only if the word's V = 0.
- R5: A status word is good only when bit 9 = 1, bits 1:0 = 0, and bits 5..2 equal V^H, F^H, F^V and F^V^H. A bad status word raises `protErr` for exactly one cycle and leaves the field, blank, data-valid and line outputs unchanged.
- R6: An end-of-active-video code whose F differs from `fieldOut` loads `lineNum` with 563 when F goes 0 to 1, and with 1 when F goes 1 to 0. This load takes the place of the increment.
- R7: After each end-of-active-video code that leaves `lineNum` non-zero, `mapErr` pulses for one cycle if F or V disagrees with the line map for the new line. The map has F = 1 on lines 563..1125, and V = 1 on lines 1..20, 561..583 and 1124..1125.
- R8: `dataValid` is active-high when `dvActiveLow` = 0 and active-low when it is 1. The pin takes effect without a clock edge.
- R9: After `ctrResetReq` has been high and is then seen low, `lineNum` and `sampleNum` are 0 from the next cycle. This clear takes precedence over a line advance or a field load in the same cycle. While `ctrResetReq` is held high, the counters are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low reset of all state |
| sampleIn | input | 10 | Incoming video word |
| dvActiveLow | input | 1 | Selects active-low data-valid |
| ctrResetReq | input | 1 | Counter clear control, acts on its falling edge |
| fieldOut | output | 1 | Current field flag |
| vBlank | output | 1 | Vertical blanking flag |
| hBlank | output | 1 | Horizontal blanking flag |
| dataValid | output | 1 | Active picture strobe, polarity per dvActiveLow |
| protErr | output | 1 | One-cycle pulse on a bad status word |
| mapErr | output | 1 | One-cycle pulse on a line-map disagreement |
| lineNum | output | 11 | Line counter, 0 until first line start |
| sampleNum | output | 12 | Sample position since last start of active video |

## Verification
Two functions of this block can act in the same cycle: the counter clear taken from the falling control bit, and a line-start code that would advance the line or reload it on a field change. The bench releases `ctrResetReq` in exactly the cycle in which an end-of-active-video status word that flips the field is sampled. It then expects `lineNum` = 0, `mapErr` quiet, and the field and blank flags still updated from that word. The same bench also walks through a full second field, up to the 1125-to-1 wrap.

// File: rtl/hdTrsPkg.sv
package hdTrsPkg;

  // Commands from control to the datapath counters.
  typedef struct packed {
    logic lineInc;
    logic loadF1;
    logic loadLine1;
    logic clrCount;
    logic hZero;
  } dpStrobe_t;

  // Decoded status word presented by the datapath.
  typedef struct packed {
    logic hit;
    logic protOk;
    logic f;
    logic v;
    logic h;
  } trsWord_t;

endpackage

// File: rtl/hdTrsDatapath.sv
module hdTrsDatapath
  import hdTrsPkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int LINES    = 1125,
  parameter int SAMPLES  = 2200,
  parameter int F1_START = 563,
  parameter int LINE_W   = 11,
  parameter int SAMP_W   = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleIn,
  input  dpStrobe_t         strobe,
  output trsWord_t          word,
  output logic [LINE_W-1:0] lineNum,
  output logic [LINE_W-1:0] lineNext,
  output logic [SAMP_W-1:0] sampleNum
);

  localparam int PRE_LEN = 3;
  localparam int FB = DATA_W - 2;
  localparam int VB = DATA_W - 3;
  localparam int HB = DATA_W - 4;
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES);
  localparam logic [LINE_W-1:0] F1_LINE   = LINE_W'(F1_START);
  localparam logic [SAMP_W-1:0] LAST_SAMP = SAMP_W'(SAMPLES - 1);

  logic [DATA_W-1:0] hist [PRE_LEN];
  logic [PRE_LEN-1:0] stageMatch;

  // Word history, hist[0] is the most recent
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PRE_LEN; i++) hist[i] <= '0;
    end else begin
      hist[0] <= sampleIn;
      for (int i = 1; i < PRE_LEN; i++) hist[i] <= hist[i-1];
    end
  end

  // Oldest stage must be all ones, the newer ones all zeros
  genvar g;
  generate
    for (g = 0; g < PRE_LEN; g++) begin : gMatch
      if (g == PRE_LEN - 1) begin : gOnes
        assign stageMatch[g] = (hist[g] == {DATA_W{1'b1}});
      end else begin : gZeros
        assign stageMatch[g] = (hist[g] == {DATA_W{1'b0}});
      end
    end
  endgenerate

  logic fBit, vBit, hBit;
  logic [3:0] protCalc;
  assign fBit = sampleIn[FB];
  assign vBit = sampleIn[VB];
  assign hBit = sampleIn[HB];
  assign protCalc = {vBit ^ hBit, fBit ^ hBit, fBit ^ vBit, fBit ^ vBit ^ hBit};

  always_comb begin
    word.hit    = &stageMatch;
    word.protOk = sampleIn[DATA_W-1] && (sampleIn[HB-1:HB-4] == protCalc)
                  && (sampleIn[HB-5:0] == '0);
    word.f      = fBit;
    word.v      = vBit;
    word.h      = hBit;
  end

  // Line counter next state
  always_comb begin
    if (strobe.clrCount)       lineNext = '0;
    else if (strobe.loadF1)    lineNext = F1_LINE;
    else if (strobe.loadLine1) lineNext = LINE_W'(1);
    else if (strobe.lineInc)   lineNext = (lineNum >= LAST_LINE) ? LINE_W'(1) : lineNum + LINE_W'(1);
    else                       lineNext = lineNum;
  end

  logic [SAMP_W-1:0] sampleNext;
  always_comb begin
    if (strobe.clrCount || strobe.hZero) sampleNext = '0;
    else if (sampleNum == LAST_SAMP)     sampleNext = '0;
    else                                 sampleNext = sampleNum + SAMP_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineNum   <= '0;
      sampleNum <= '0;
    end else begin
      lineNum   <= lineNext;
      sampleNum <= sampleNext;
    end
  end

endmodule

// File: rtl/hdTrsControl.sv
module hdTrsControl
  import hdTrsPkg::*;
#(
  parameter int F1_START   = 563,
  parameter int VA_END     = 20,
  parameter int VB_START   = 561,
  parameter int VB_END     = 583,
  parameter int VC_START   = 1124,
  parameter int LINE_W     = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  trsWord_t          word,
  input  logic [LINE_W-1:0] lineNext,
  input  logic              ctrResetReq,
  input  logic              dvActiveLow,
  output dpStrobe_t         strobe,
  output logic              fieldOut,
  output logic              vBlank,
  output logic              hBlank,
  output logic              dataValid,
  output logic              protErr,
  output logic              mapErr
);

  localparam logic [LINE_W-1:0] F1L = LINE_W'(F1_START);
  localparam logic [LINE_W-1:0] VAE = LINE_W'(VA_END);
  localparam logic [LINE_W-1:0] VBS = LINE_W'(VB_START);
  localparam logic [LINE_W-1:0] VBE = LINE_W'(VB_END);
  localparam logic [LINE_W-1:0] VCS = LINE_W'(VC_START);

  function automatic logic mapField(input logic [LINE_W-1:0] l);
    return l >= F1L;
  endfunction

  function automatic logic mapVblank(input logic [LINE_W-1:0] l);
    return (l <= VAE) || ((l >= VBS) && (l <= VBE)) || (l >= VCS);
  endfunction

  logic goodWord, badWord, eavHit, savHit, softFall, reqPrev, dvInt;

  assign goodWord = word.hit && word.protOk;
  assign badWord  = word.hit && !word.protOk;
  assign eavHit   = goodWord && word.h;
  assign savHit   = goodWord && !word.h;
  assign softFall = reqPrev && !ctrResetReq;

  always_comb begin
    strobe.clrCount  = softFall;
    strobe.lineInc   = eavHit;
    strobe.loadF1    = eavHit && word.f && !fieldOut;
    strobe.loadLine1 = eavHit && !word.f && fieldOut;
    strobe.hZero     = savHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fieldOut <= 1'b0;
      vBlank   <= 1'b1;
      hBlank   <= 1'b1;
      dvInt    <= 1'b0;
      protErr  <= 1'b0;
      mapErr   <= 1'b0;
      reqPrev  <= 1'b0;
    end else begin
      reqPrev <= ctrResetReq;
      protErr <= badWord;
      mapErr  <= eavHit && !softFall && (lineNext != '0) &&
                 ((word.f != mapField(lineNext)) || (word.v != mapVblank(lineNext)));
      if (eavHit) begin
        fieldOut <= word.f;
        vBlank   <= word.v;
        hBlank   <= 1'b1;
        dvInt    <= 1'b0;
      end else if (savHit) begin
        hBlank   <= 1'b0;
        dvInt    <= !word.v;
      end
    end
  end

  assign dataValid = dvInt ^ dvActiveLow;

endmodule

// File: rtl/hdTimingDecoder.sv
module hdTimingDecoder
  import hdTrsPkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int LINES    = 1125,
  parameter int SAMPLES  = 2200,
  parameter int F1_START = 563,
  parameter int VA_END   = 20,
  parameter int VB_START = 561,
  parameter int VB_END   = 583,
  parameter int VC_START = 1124,
  localparam int LINE_W  = $clog2(LINES + 1),
  localparam int SAMP_W  = $clog2(SAMPLES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic              dvActiveLow,
  input  logic              ctrResetReq,
  output logic              fieldOut,
  output logic              vBlank,
  output logic              hBlank,
  output logic              dataValid,
  output logic              protErr,
  output logic              mapErr,
  output logic [LINE_W-1:0] lineNum,
  output logic [SAMP_W-1:0] sampleNum
);

  dpStrobe_t         strobe;
  trsWord_t          word;
  logic [LINE_W-1:0] lineNext;

  hdTrsDatapath #(
    .DATA_W(DATA_W), .LINES(LINES), .SAMPLES(SAMPLES),
    .F1_START(F1_START), .LINE_W(LINE_W), .SAMP_W(SAMP_W)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .strobe(strobe),
    .word(word), .lineNum(lineNum), .lineNext(lineNext), .sampleNum(sampleNum)
  );

  hdTrsControl #(
    .F1_START(F1_START), .VA_END(VA_END), .VB_START(VB_START),
    .VB_END(VB_END), .VC_START(VC_START), .LINE_W(LINE_W)
  ) uControl (
    .clk(clk), .rstN(rstN), .word(word), .lineNext(lineNext),
    .ctrResetReq(ctrResetReq), .dvActiveLow(dvActiveLow), .strobe(strobe),
    .fieldOut(fieldOut), .vBlank(vBlank), .hBlank(hBlank),
    .dataValid(dataValid), .protErr(protErr), .mapErr(mapErr)
  );

endmodule

// File: rtl/hdTimingDecoderChk.sv
module hdTimingDecoderChk #(
  parameter int LINES    = 1125,
  parameter int F1_START = 563,
  parameter int LINE_W   = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              dvActiveLow,
  input logic              fieldOut,
  input logic              vBlank,
  input logic              hBlank,
  input logic              dataValid,
  input logic              protErr,
  input logic [LINE_W-1:0] lineNum
);

  localparam logic [LINE_W-1:0] F1L  = LINE_W'(F1_START);
  localparam logic [LINE_W-1:0] LAST = LINE_W'(LINES);

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (lineNum == '0) && hBlank && vBlank && !fieldOut);

  assert_line_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    lineNum <= LAST);

  assert_dv_in_active_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid != dvActiveLow) |-> !hBlank);

  assert_prot_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    protErr |-> $stable(fieldOut) && $stable(vBlank) && $stable(hBlank));

  assert_prot_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    protErr |=> !protErr);

  assert_field_rise_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fieldOut) |-> (lineNum == F1L) || (lineNum == '0));

  assert_field_fall_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fieldOut) |-> (lineNum == LINE_W'(1)) || (lineNum == '0));

endmodule

bind hdTimingDecoder hdTimingDecoderChk #(
  .LINES(LINES), .F1_START(F1_START), .LINE_W(LINE_W)
) uChk (
  .clk(clk), .rstN(rstN), .dvActiveLow(dvActiveLow), .fieldOut(fieldOut),
  .vBlank(vBlank), .hBlank(hBlank), .dataValid(dataValid),
  .protErr(protErr), .lineNum(lineNum)
);

// File: tb/tb_hdTimingDecoder.sv
`timescale 1ns/1ps
module tb_hdTimingDecoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  sampleIn = '0;
  logic        dvActiveLow = 1'b0;
  logic        ctrResetReq = 1'b0;
  logic        fieldOut, vBlank, hBlank, dataValid, protErr, mapErr;
  logic [10:0] lineNum;
  logic [11:0] sampleNum;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hdTimingDecoder dut (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .dvActiveLow(dvActiveLow),
    .ctrResetReq(ctrResetReq), .fieldOut(fieldOut), .vBlank(vBlank),
    .hBlank(hBlank), .dataValid(dataValid), .protErr(protErr),
    .mapErr(mapErr), .lineNum(lineNum), .sampleNum(sampleNum)
  );

  // {corrupt, F, V, H, expLine[10:0], expF, expV, expH, expDv, expPe, expMe}
  localparam int NVEC = 10;
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 1'b1, 1'b1, 11'd1,   6'b011000},
    {1'b0, 1'b0, 1'b1, 1'b0, 11'd1,   6'b010000},
    {1'b0, 1'b0, 1'b1, 1'b1, 11'd2,   6'b011000},
    {1'b0, 1'b0, 1'b0, 1'b0, 11'd2,   6'b010100},
    {1'b1, 1'b0, 1'b0, 1'b1, 11'd2,   6'b010110},
    {1'b0, 1'b0, 1'b0, 1'b1, 11'd3,   6'b001001},
    {1'b0, 1'b1, 1'b1, 1'b1, 11'd563, 6'b111000},
    {1'b0, 1'b1, 1'b1, 1'b0, 11'd563, 6'b110000},
    {1'b0, 1'b1, 1'b1, 1'b1, 11'd564, 6'b111000},
    {1'b0, 1'b0, 1'b1, 1'b1, 11'd1,   6'b011000}
  };

  function automatic logic [9:0] statusWord(input logic f, input logic v,
                                            input logic h, input logic corrupt);
    logic [9:0] w;
    w = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
    if (corrupt) w[5] = ~w[5];
    return w;
  endfunction

  function automatic logic tbVblank(input int n);
    return (n <= 20) || (n >= 561 && n <= 583) || (n >= 1124);
  endfunction

  task automatic putWord(input logic [9:0] w);
    sampleIn = w;
    @(negedge clk);
  endtask

  task automatic sendTrs(input logic f, input logic v, input logic h, input logic c);
    putWord(10'h3FF);
    putWord(10'h000);
    putWord(10'h000);
    putWord(statusWord(f, v, h, c));
  endtask

  task automatic check(input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 lineNum", lineNum, 0);
    check("R1 hBlank", hBlank, 1);
    check("R1 vBlank", vBlank, 1);
    check("R1 dataValid", dataValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 fieldOut after release", fieldOut, 0);
    check("R1 protErr", protErr, 0);

    // Table walk: R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      logic [20:0] e;
      e = VEC[i];
      sendTrs(e[19], e[18], e[17], e[20]);
      check($sformatf("R3/R6 vec%0d lineNum", i), lineNum, e[16:6]);
      check($sformatf("R3 vec%0d fieldOut", i), fieldOut, e[5]);
      check($sformatf("R3 vec%0d vBlank", i), vBlank, e[4]);
      check($sformatf("R4 vec%0d hBlank", i), hBlank, e[3]);
      check($sformatf("R4 vec%0d dataValid", i), dataValid, e[2]);
      check($sformatf("R5 vec%0d protErr", i), protErr, e[1]);
      check($sformatf("R7 vec%0d mapErr", i), mapErr, e[0]);
    end

    // R2: broken preamble, status-like word ignored
    putWord(10'h3FF); putWord(10'h000); putWord(10'h001);
    putWord(statusWord(1'b0, 1'b1, 1'b0, 1'b0));
    check("R2 hBlank unchanged", hBlank, 1);
    check("R2 lineNum unchanged", lineNum, 1);
    check("R2 protErr quiet", protErr, 0);

    // R4: sample counter from start of active video
    sendTrs(1'b0, 1'b0, 1'b0, 1'b0);
    check("R4 sampleNum after SAV", sampleNum, 0);
    check("R4 dataValid active", dataValid, 1);
    for (int k = 0; k < 5; k++) putWord(10'h200);
    check("R4 sampleNum counts", sampleNum, 5);

    // R8: polarity
    dvActiveLow = 1'b1;
    #1;
    check("R8 active-low active", dataValid, 0);
    sendTrs(1'b0, 1'b1, 1'b1, 1'b0);
    check("R8 active-low inactive", dataValid, 1);
    check("R3 lineNum 2", lineNum, 2);
    dvActiveLow = 1'b0;

    // R9: counter clear on falling control bit
    ctrResetReq = 1'b1;
    putWord(10'h200);
    check("R9 held high no effect", lineNum, 2);
    ctrResetReq = 1'b0;
    putWord(10'h200);
    check("R9 lineNum cleared", lineNum, 0);
    check("R9 sampleNum cleared", sampleNum, 0);

    // R3 wrap across second field
    sendTrs(1'b1, 1'b1, 1'b1, 1'b0);
    check("R6 field rise to 563", lineNum, 563);
    for (int n = 564; n <= 1125; n++) sendTrs(1'b1, tbVblank(n), 1'b1, 1'b0);
    check("R3 lineNum at 1125", lineNum, 1125);
    check("R7 map quiet on good field", mapErr, 0);
    sendTrs(1'b1, 1'b1, 1'b1, 1'b0);
    check("R3 wrap to 1", lineNum, 1);
    check("R7 field 1 on line 1", mapErr, 1);

    // R9 with R6: clear and field fall in the same cycle
    ctrResetReq = 1'b1;
    putWord(10'h3FF); putWord(10'h000); putWord(10'h000);
    ctrResetReq = 1'b0;
    putWord(statusWord(1'b0, 1'b0, 1'b1, 1'b0));
    check("R9 clear wins over load", lineNum, 0);
    check("R3 field still updated", fieldOut, 0);
    check("R3 vBlank still updated", vBlank, 0);
    check("R7 no map check on clear", mapErr, 0);

    // R1 mid-run reset with active-low polarity
    sendTrs(1'b0, 1'b0, 1'b0, 1'b0);
    dvActiveLow = 1'b1;
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset lineNum", lineNum, 0);
    check("R1 reset hBlank", hBlank, 1);
    check("R1 reset dataValid inactive", dataValid, 1);
    check("R1 reset sampleNum", sampleNum, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule